// File: doc/BRIEF.md
# Line Time-Redistribution Buffer

This block sits between the input-rate side and the output-rate side of a television line-standards converter. On the input side a start-of-active-video strobe opens a window of a fixed number of samples, set by a parameter. The window is made a little wider than the visible output line so that horizontal position can be trimmed downstream. Only the samples inside that window are stored. Horizontal blanking and sync markers never enter the buffer, so each stored line is a run of exactly `LINE_LEN` words.

The output side runs on its own clock. The output line timing raises a one-cycle line request, and the block then streams one complete stored line on consecutive output clocks. Lines are committed, admitted and released only as whole units, so the two sides can never lose their alignment to line boundaries. The write side publishes a count of committed lines, and the read side publishes its word pointer. Both cross between clock domains in Gray code.

Running out of room or out of lines is allowed only during vertical blanking. Each side has a blanking qualifier input. When the condition occurs outside vertical blanking, a sticky error flag on that side is set. Whenever no line is being streamed, the output is forced to zero.

Top module: `line_retime_buf`

## Requirements
- R1: After a cycle with `w_sav` high, the `w_data` values on the next `LINE_LEN` write clocks are stored as one line. Samples driven after that window, before the next SAV, are not stored.
- R2: An accepted line request makes `r_valid` high for exactly `LINE_LEN` consecutive read clocks. The samples come out in the order they were written, and lines come out in the order they were committed.
- R3: If a new `w_sav` arrives before the current window has taken all `LINE_LEN` samples, the partial line is discarded. It is never readable, and the new window starts from the same place.
- R4: `r_empty` is high exactly when no complete unread line is buffered. A line request is accepted only when `r_empty` is low and no line is being streamed.
- R5: A line request made while a line is being streamed has no effect. No extra samples appear, and no further line is consumed.
- R6: At each SAV, if fewer than `LINE_LEN` words are free, the whole line is refused and none of its samples are stored. `w_full` is high exactly while fewer than `LINE_LEN` words are free.
- R7: A refused line with `w_vblank` low sets `w_ovf_err`. A refused line with `w_vblank` high does not. The flag stays set until `w_err_clr` is pulsed.
- R8: A line request while idle and empty, with `r_vblank` low, sets `r_unf_err`. The same request with `r_vblank` high does not. The flag stays set until `r_err_clr` is pulsed.
- R9: After reset: `r_empty`=1, `w_full`=0, `w_ovf_err`=0, `r_unf_err`=0, `r_valid`=0.
- R10: `r_data` is zero on every read clock where `r_valid` is low.
- R11: Storage wraps around the `2**ADDR_W` words without corrupting lines, across any mix of writes and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_clk | input | 1 | Input-side sample clock |
| w_rst_n | input | 1 | Input-side asynchronous reset, active low |
| w_sav | input | 1 | Start-of-active-video strobe, one clock |
| w_data | input | DATA_W | Input sample |
| w_vblank | input | 1 | Input-side vertical blanking qualifier |
| w_err_clr | input | 1 | Clears the overflow error |
| w_full | output | 1 | Less than one line of free space |
| w_ovf_err | output | 1 | Sticky overflow error |
| r_clk | input | 1 | Output-side sample clock |
| r_rst_n | input | 1 | Output-side asynchronous reset, active low |
| r_line_req | input | 1 | Request for one whole line |
| r_vblank | input | 1 | Output-side vertical blanking qualifier |
| r_err_clr | input | 1 | Clears the underflow error |
| r_data | output | DATA_W | Output sample, zero when not valid |
| r_valid | output | 1 | Output sample valid |
| r_empty | output | 1 | No complete line buffered |
| r_unf_err | output | 1 | Sticky underflow error |

## Verification
A corrupted write or commit pointer shows up as wrong sample values, or a wrong line order, in the very next line read out. Most such faults also put a partial line's samples on the output. A miscounted window or read counter gives a run of `r_valid` longer or shorter than `LINE_LEN` within one line period. A wrong space or line count is seen at `w_full` or `r_empty` a few clocks after the Gray-code pointers settle. Under-counting free space refuses a line that should be stored, and that line is then missing from the sequence read back.

// File: rtl/lrb_gray_xfer.sv
module lrb_gray_xfer #(
  parameter int W = 4
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic [W-1:0] src_bin,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_bin
);
  function automatic logic [W-1:0] bin_to_gray(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] g_src, s1, s2;

  always_ff @(posedge src_clk or negedge src_rst_n)
    if (!src_rst_n) g_src <= '0;
    else            g_src <= bin_to_gray(src_bin);

  always_ff @(posedge dst_clk or negedge dst_rst_n)
    if (!dst_rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= g_src;
      s2 <= s1;
    end

  assign dst_bin = gray_to_bin(s2);

  // R11
  gray_step_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $countones(g_src ^ $past(g_src)) <= 1);
endmodule

// File: rtl/lrb_mem.sv
module lrb_mem #(
  parameter int DW = 8,
  parameter int AW = 12
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk)
    if (we) store[waddr] <= wdata;

  assign rdata = store[raddr];
endmodule

// File: rtl/lrb_wr.sv
module lrb_wr #(
  parameter int DW       = 8,
  parameter int AW       = 12,
  parameter int LINE_LEN = 768,
  parameter int LEN_W    = 10,
  parameter int LC_W     = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sav,
  input  logic [DW-1:0]   din,
  input  logic            vblank,
  input  logic            err_clr,
  input  logic [AW:0]     rptr_sync,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_din,
  output logic [LC_W-1:0] lines_done,
  output logic            full,
  output logic            ovf_err
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [PW-1:0] free_words(input logic [PW-1:0] commit,
                                               input logic [PW-1:0] rd);
    return PW'(DEPTH) - (commit - rd);
  endfunction

  logic [PW-1:0]    commit_q, work_q;
  logic [LEN_W-1:0] left_q;
  logic [LC_W-1:0]  lines_q;
  logic             err_q;

  wire room     = free_words(commit_q, rptr_sync) >= PW'(LINE_LEN);
  wire ev_start = sav & room;
  wire ev_drop  = sav & ~room;
  wire ev_take  = ~sav & (left_q != '0);
  wire ev_done  = ev_take & (left_q == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      commit_q <= '0;
      work_q   <= '0;
      left_q   <= '0;
      lines_q  <= '0;
    end else if (sav) begin
      left_q <= ev_start ? LEN_W'(LINE_LEN) : '0;
      work_q <= commit_q;
    end else if (ev_take) begin
      work_q <= work_q + PW'(1);
      left_q <= left_q - LEN_W'(1);
      if (ev_done) begin
        commit_q <= work_q + PW'(1);
        lines_q  <= lines_q + LC_W'(1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 err_q <= 1'b0;
    else if (ev_drop & ~vblank) err_q <= 1'b1;
    else if (err_clr)           err_q <= 1'b0;

  assign mem_we     = ev_take;
  assign mem_addr   = work_q[AW-1:0];
  assign mem_din    = din;
  assign lines_done = lines_q;
  assign full       = ~room;
  assign ovf_err    = err_q;

  // R3
  commit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q != $past(commit_q) |-> commit_q == $past(commit_q) + PW'(LINE_LEN));
  // R6
  space_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_q - rptr_sync) <= PW'(DEPTH));
  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !err_clr |=> err_q);
endmodule

// File: rtl/lrb_rd.sv
module lrb_rd #(
  parameter int DW       = 8,
  parameter int AW       = 12,
  parameter int LINE_LEN = 768,
  parameter int LEN_W    = 10,
  parameter int LC_W     = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            vblank,
  input  logic            err_clr,
  input  logic [LC_W-1:0] wlines_sync,
  input  logic [DW-1:0]   mem_q,
  output logic [AW-1:0]   mem_addr,
  output logic [AW:0]     rptr,
  output logic [DW-1:0]   dout,
  output logic            valid,
  output logic            empty,
  output logic            unf_err
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int MAXL  = DEPTH / LINE_LEN;

  function automatic logic [LC_W-1:0] lines_held(input logic [LC_W-1:0] wl,
                                                 input logic [LC_W-1:0] rl);
    return wl - rl;
  endfunction

  logic [PW-1:0]    rptr_q;
  logic [LEN_W-1:0] left_q, run_q;
  logic [LC_W-1:0]  rlines_q;
  logic [DW-1:0]    data_q;
  logic             valid_q, err_q;

  wire [LC_W-1:0] avail = lines_held(wlines_sync, rlines_q);
  wire idle      = (left_q == '0);
  wire none      = (avail == '0);
  wire ev_accept = req & idle & ~none;
  wire ev_starve = req & idle & none;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rptr_q   <= '0;
      left_q   <= '0;
      rlines_q <= '0;
      data_q   <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= ~idle;
      data_q  <= idle ? '0 : mem_q;
      if (ev_accept) begin
        left_q   <= LEN_W'(LINE_LEN);
        rlines_q <= rlines_q + LC_W'(1);
      end else if (!idle) begin
        left_q <= left_q - LEN_W'(1);
        rptr_q <= rptr_q + PW'(1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   err_q <= 1'b0;
    else if (ev_starve & ~vblank) err_q <= 1'b1;
    else if (err_clr)             err_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run_q <= '0;
    else        run_q <= valid_q ? run_q + LEN_W'(1) : '0;

  assign mem_addr = rptr_q[AW-1:0];
  assign rptr     = rptr_q;
  assign dout     = data_q;
  assign valid    = valid_q;
  assign empty    = none;
  assign unf_err  = err_q;

  // R4
  lines_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avail <= LC_W'(MAXL));
  // R2
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_q) |-> run_q == LEN_W'(LINE_LEN));
  // R10
  blank_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> data_q == '0);
  // R8
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !err_clr |=> err_q);
endmodule

// File: rtl/line_retime_buf.sv
module line_retime_buf #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 12,
  parameter int LINE_LEN = 768
) (
  input  logic              w_clk,
  input  logic              w_rst_n,
  input  logic              w_sav,
  input  logic [DATA_W-1:0] w_data,
  input  logic              w_vblank,
  input  logic              w_err_clr,
  output logic              w_full,
  output logic              w_ovf_err,
  input  logic              r_clk,
  input  logic              r_rst_n,
  input  logic              r_line_req,
  input  logic              r_vblank,
  input  logic              r_err_clr,
  output logic [DATA_W-1:0] r_data,
  output logic              r_valid,
  output logic              r_empty,
  output logic              r_unf_err
);
  localparam int LEN_W = $clog2(LINE_LEN + 1);
  localparam int LC_W  = ADDR_W + 1;
  localparam int PW    = ADDR_W + 1;

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic [LC_W-1:0]   wlines_src, wlines_dst;
  logic [PW-1:0]     rptr_src, rptr_dst;

  lrb_wr #(.DW(DATA_W), .AW(ADDR_W), .LINE_LEN(LINE_LEN), .LEN_W(LEN_W), .LC_W(LC_W)) u_wr (
    .clk(w_clk), .rst_n(w_rst_n), .sav(w_sav), .din(w_data), .vblank(w_vblank),
    .err_clr(w_err_clr), .rptr_sync(rptr_dst), .mem_we(mem_we), .mem_addr(mem_waddr),
    .mem_din(mem_wdata), .lines_done(wlines_src), .full(w_full), .ovf_err(w_ovf_err));

  lrb_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .wclk(w_clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata));

  lrb_gray_xfer #(.W(LC_W)) u_lines_x (
    .src_clk(w_clk), .src_rst_n(w_rst_n), .src_bin(wlines_src),
    .dst_clk(r_clk), .dst_rst_n(r_rst_n), .dst_bin(wlines_dst));

  lrb_gray_xfer #(.W(PW)) u_rptr_x (
    .src_clk(r_clk), .src_rst_n(r_rst_n), .src_bin(rptr_src),
    .dst_clk(w_clk), .dst_rst_n(w_rst_n), .dst_bin(rptr_dst));

  lrb_rd #(.DW(DATA_W), .AW(ADDR_W), .LINE_LEN(LINE_LEN), .LEN_W(LEN_W), .LC_W(LC_W)) u_rd (
    .clk(r_clk), .rst_n(r_rst_n), .req(r_line_req), .vblank(r_vblank),
    .err_clr(r_err_clr), .wlines_sync(wlines_dst), .mem_q(mem_rdata),
    .mem_addr(mem_raddr), .rptr(rptr_src), .dout(r_data), .valid(r_valid),
    .empty(r_empty), .unf_err(r_unf_err));
endmodule

// File: tb/line_retime_buf_test.sv
module line_retime_buf_test;
  localparam int DW = 8;
  localparam int AW = 5;
  localparam int L  = 6;
  localparam int DEPTH = 1 << AW;

  logic w_clk = 0, r_clk = 0, rst_n = 0;
  logic w_sav = 0, w_vblank = 0, w_err_clr = 0;
  logic [DW-1:0] w_data = '0;
  logic r_line_req = 0, r_vblank = 0, r_err_clr = 0;
  logic w_full, w_ovf_err, r_valid, r_empty, r_unf_err;
  logic [DW-1:0] r_data;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  int line_q[$];

  always #2 w_clk = ~w_clk;
  always #3 r_clk = ~r_clk;

  line_retime_buf #(.DATA_W(DW), .ADDR_W(AW), .LINE_LEN(L)) uut (
    .w_clk(w_clk), .w_rst_n(rst_n), .w_sav(w_sav), .w_data(w_data),
    .w_vblank(w_vblank), .w_err_clr(w_err_clr), .w_full(w_full), .w_ovf_err(w_ovf_err),
    .r_clk(r_clk), .r_rst_n(rst_n), .r_line_req(r_line_req), .r_vblank(r_vblank),
    .r_err_clr(r_err_clr), .r_data(r_data), .r_valid(r_valid), .r_empty(r_empty),
    .r_unf_err(r_unf_err));

  function automatic int pat(int base, int i);
    return (base * 37 + i * 11 + 5) & 8'hFF;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge r_clk);
    repeat (8) @(negedge w_clk);
  endtask

  // commit: bench expects a full window to be taken
  task automatic write_line(int base, int nsamp, bit vb, bit commit);
    @(negedge w_clk);
    w_vblank = vb;
    w_sav = 1;
    @(negedge w_clk);
    w_sav = 0;
    for (int i = 0; i < nsamp; i++) begin
      w_data = DW'(pat(base, i));
      @(negedge w_clk);
    end
    w_data = 8'hEE;
    if (commit && (line_q.size() * L + L <= DEPTH)) line_q.push_back(base);
  endtask

  task automatic read_line(string tag, bit dup);
    int base, got;
    base = line_q.pop_front();
    got = 0;
    @(negedge r_clk);
    r_line_req = 1;
    @(negedge r_clk);
    r_line_req = 0;
    for (int j = 0; j < L + 5; j++) begin
      if (dup && j == 2) r_line_req = 1;
      if (dup && j == 3) r_line_req = 0;
      if (r_valid) begin
        chk(tag, int'(r_data), pat(base, got));
        got++;
      end else begin
        chk("R10 blank", int'(r_data), 0);
      end
      @(negedge r_clk);
    end
    chk({tag, " count"}, got, L);
  endtask

  always @(posedge w_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge w_clk);
    rst_n = 1;
    repeat (2) @(negedge r_clk);
    // R9 reset state
    chk("R9 r_empty", int'(r_empty), 1);
    chk("R9 w_full", int'(w_full), 0);
    chk("R9 w_ovf_err", int'(w_ovf_err), 0);
    chk("R9 r_unf_err", int'(r_unf_err), 0);
    chk("R9 r_valid", int'(r_valid), 0);
    chk("R10 reset data", int'(r_data), 0);

    // R1 / R2: single line
    write_line(1, L, 0, 1);
    settle();
    chk("R4 not empty", int'(r_empty), 0);
    read_line("R1 R2 line", 0);
    settle();
    chk("R4 empty again", int'(r_empty), 1);

    // R1: samples beyond the window are not stored
    write_line(2, L + 3, 0, 1);
    settle();
    read_line("R1 window", 0);
    settle();
    chk("R1 no extra line", int'(r_empty), 1);

    // R3: partial line cancelled by early SAV
    write_line(3, 3, 0, 0);
    write_line(4, L, 0, 1);
    settle();
    read_line("R3 replacement", 0);
    settle();
    chk("R3 partial unreadable", int'(r_empty), 1);

    // R5: request while streaming ignored
    write_line(5, L, 0, 1);
    write_line(6, L, 0, 1);
    settle();
    read_line("R5 first", 1);
    settle();
    chk("R5 second still held", int'(r_empty), 0);
    read_line("R5 second", 0);
    settle();

    // R8 / R4: request while empty
    r_vblank = 0;
    @(negedge r_clk); r_line_req = 1;
    @(negedge r_clk); r_line_req = 0;
    for (int j = 0; j < 4; j++) begin
      chk("R4 no output when empty", int'(r_valid), 0);
      @(negedge r_clk);
    end
    chk("R8 unf set", int'(r_unf_err), 1);
    repeat (3) @(negedge r_clk);
    chk("R8 unf held", int'(r_unf_err), 1);
    r_err_clr = 1; @(negedge r_clk); r_err_clr = 0; @(negedge r_clk);
    chk("R8 unf cleared", int'(r_unf_err), 0);
    r_vblank = 1;
    @(negedge r_clk); r_line_req = 1;
    @(negedge r_clk); r_line_req = 0;
    repeat (2) @(negedge r_clk);
    chk("R8 vblank tolerated", int'(r_unf_err), 0);
    r_vblank = 0;

    // R6 / R7: fill to capacity
    for (int k = 0; k < DEPTH / L; k++) write_line(10 + k, L, 0, 1);
    settle();
    chk("R6 full", int'(w_full), 1);
    write_line(40, L, 1, 1);
    @(negedge w_clk);
    chk("R7 vblank drop no err", int'(w_ovf_err), 0);
    write_line(41, L, 0, 1);
    @(negedge w_clk);
    chk("R7 ovf set", int'(w_ovf_err), 1);
    repeat (3) @(negedge w_clk);
    chk("R7 ovf held", int'(w_ovf_err), 1);
    w_err_clr = 1; @(negedge w_clk); w_err_clr = 0; @(negedge w_clk);
    chk("R7 ovf cleared", int'(w_ovf_err), 0);
    chk("R6 queue model", line_q.size(), DEPTH / L);
    while (line_q.size() > 0) read_line("R6 kept lines", 0);
    settle();
    chk("R6 dropped not stored", int'(r_empty), 1);
    chk("R6 space freed", int'(w_full), 0);

    // R11: wrap-around sweep with varying burst sizes
    for (int it = 0; it < 30; it++) begin
      int n;
      n = 1 + (it % 4);
      for (int k = 0; k < n; k++) write_line(100 + it * 5 + k, L, 0, 1);
      settle();
      for (int k = 0; k < n; k++) read_line("R11 sweep", 0);
      settle();
      chk("R11 drained", int'(r_empty), 1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule